// File: doc/BRIEF.md
# Word-Length-Aware Special Character Detector

This block sits between a serial receiver and its receive FIFO. Each character the receiver delivers is checked against a software-programmed special character, and the character always continues on to the FIFO unaltered. When a character matches, a sticky status bit is raised so that the interrupt logic can report a special-character event. The status bit stays set until an explicit clear pulse arrives.

The comparison covers only the bits that belong to the active character length. A 2-bit length code selects 5, 6, 7 or 8 data bits. Any bits above the active length are ignored on both the received byte and the programmed character. Bit 0 of both operands is the first bit received on the line, which is the LSB. Detection runs only while a dedicated enable input is high. Data and valid are registered once, and the status bit changes on the same clock edge as the character it reports.

Top module: `spchar_detect`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_valid`, `out_data` and `hit_flag` read 0.
- R2: `rx_data` sampled with `rx_valid` high appears unchanged on `out_data`, with `out_valid` high, exactly one cycle later. This also holds for a matching character. A cycle with `rx_valid` low gives `out_valid` low one cycle later.
- R3: When `det_en` is high and a valid character matches `match_char`, `hit_flag` goes high on the same edge that raises `out_valid` for that character.
- R4: The length code `wlen` selects how many low bits are compared: 00 compares 5 bits, 01 compares 6, 10 compares 7 and 11 compares 8. Bit 0 of both operands is the first-received LSB.
- R5: Bits at or above the selected length have no effect on the match result, whatever their values in `rx_data` or `match_char`.
- R6: With `det_en` low, no character sets `hit_flag`.
- R7: `hit_flag` stays high until `hit_clr` is sampled high in a cycle with no new match. It then reads 0 in the next cycle.
- R8: If a new match and `hit_clr` occur in the same cycle, `hit_flag` is high in the next cycle.
- R9: A cycle with `rx_valid` low never sets `hit_flag`, even when `rx_data` equals `match_char`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | DATA_W | Received character |
| rx_valid | input | 1 | `rx_data` holds a new character |
| match_char | input | DATA_W | Programmed special character |
| wlen | input | 2 | Length code: 00=5, 01=6, 10=7, 11=8 bits |
| det_en | input | 1 | Detection enable |
| hit_clr | input | 1 | Clear pulse for the status bit |
| out_data | output | DATA_W | Character forwarded to the FIFO |
| out_valid | output | 1 | `out_data` is a new character |
| hit_flag | output | 1 | Sticky special-character status |

## Verification
The length masking is tested with pairs of characters for each of the four length codes. In each pair, one character differs from the programmed value only in the first bit above the active length, and the other differs only in the top active bit. The first must match and the second must not, which pins the mask boundary to within one bit for every code. Separate patterns cover the following cases:
- the upper bits of both operands differ while the low bits agree;
- a matching byte is sent with detection disabled;
- a matching byte is presented with its valid strobe low;
- a match arrives in the same cycle as a clear.

These patterns separate the enable and valid qualification from the sticky-flag priority.

// File: rtl/spchar_pkg.sv
package spchar_pkg;
  localparam int CODE_W = 2;
  typedef enum logic [CODE_W-1:0] {
    LEN_5 = 2'b00,
    LEN_6 = 2'b01,
    LEN_7 = 2'b10,
    LEN_8 = 2'b11
  } len_code_e;
endpackage

// File: rtl/spchar_mask_gen.sv
module spchar_mask_gen #(
  parameter int DATA_W   = 8,
  parameter int MIN_WLEN = 5,
  parameter int CODE_W   = 2
) (
  input  logic [CODE_W-1:0] len_code,
  output logic [DATA_W-1:0] cmp_mask
);
  localparam int NUM_LEN = 1 << CODE_W;

  // bit i compares when i < MIN_WLEN + len_code
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam int THR = i - MIN_WLEN;
    if (THR < 0) begin : g_always
      assign cmp_mask[i] = 1'b1;
    end else if (THR >= NUM_LEN - 1) begin : g_never
      assign cmp_mask[i] = 1'b0;
    end else begin : g_sel
      assign cmp_mask[i] = (int'(len_code) > THR);
    end
  end
endmodule

// File: rtl/spchar_compare.sv
module spchar_compare #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] char_in,
  input  logic [DATA_W-1:0] char_ref,
  input  logic [DATA_W-1:0] cmp_mask,
  input  logic              char_vld,
  input  logic              enable,
  output logic              hit
);
  logic [DATA_W-1:0] diff;

  always_comb begin
    diff = (char_in ^ char_ref) & cmp_mask;
    hit  = char_vld && enable && (diff == '0);
  end
endmodule

// File: rtl/spchar_status.sv
module spchar_status (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  p_hit_sets_r8: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !flag);
  p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (rst)
    (!flag && !hit) |=> !flag);
endmodule

// File: rtl/spchar_detect.sv
module spchar_detect #(
  parameter int DATA_W   = 8,
  parameter int MIN_WLEN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] match_char,
  input  logic [1:0]        wlen,
  input  logic              det_en,
  input  logic              hit_clr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              hit_flag
);
  import spchar_pkg::*;

  logic [DATA_W-1:0] mask_w;
  logic              hit_w;

  spchar_mask_gen #(.DATA_W(DATA_W), .MIN_WLEN(MIN_WLEN), .CODE_W(CODE_W)) u_mask (
    .len_code (wlen),
    .cmp_mask (mask_w)
  );

  spchar_compare #(.DATA_W(DATA_W)) u_cmp (
    .char_in  (rx_data),
    .char_ref (match_char),
    .cmp_mask (mask_w),
    .char_vld (rx_valid),
    .enable   (det_en),
    .hit      (hit_w)
  );

  spchar_status u_stat (
    .clk  (clk),
    .rst  (rst),
    .hit  (hit_w),
    .clr  (hit_clr),
    .flag (hit_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= rx_valid;
      if (rx_valid) out_data <= rx_data;
    end
  end

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> out_valid);
  p_idle_delay_r2: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !out_valid);
  p_data_delay_r2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> (out_data == $past(rx_data)));
  p_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    (!det_en && !hit_flag && !hit_clr) |=> !hit_flag);
  p_invalid_r9: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !hit_flag) |=> !hit_flag);
endmodule

// File: tb/spchar_detect_tb.sv
module spchar_detect_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [DW-1:0] rx_data, match_char, out_data;
  logic          rx_valid, det_en, hit_clr, out_valid, hit_flag;
  logic [1:0]    wlen;
  int            total = 0;
  int            bad   = 0;

  always #5 clk = ~clk;

  spchar_detect #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .match_char(match_char), .wlen(wlen), .det_en(det_en), .hit_clr(hit_clr),
    .out_data(out_data), .out_valid(out_valid), .hit_flag(hit_flag)
  );

  function automatic logic exp_match(logic [7:0] d, logic [7:0] m, logic [1:0] c);
    logic [7:0] msk;
    msk = 8'((9'd1 << (5 + int'(c))) - 9'd1);
    return ((d ^ m) & msk) == 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, sample outputs at the next negedge
  task automatic cycle(logic [7:0] d, logic v, logic c);
    rx_data = d; rx_valid = v; hit_clr = c;
    @(negedge clk);
    rx_valid = 1'b0; hit_clr = 1'b0;
  endtask

  task automatic do_clear();
    cycle(8'h00, 1'b0, 1'b1);
    chk("R7 clear", 32'(hit_flag), 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1; rx_valid = 1'b0; rx_data = 8'hFF; match_char = 8'hFF;
    wlen = 2'b11; det_en = 1'b1; hit_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    chk("R1 flag in reset", 32'(hit_flag), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 data after reset", 32'(out_data), 32'd0);
    chk("R1 flag after reset", 32'(hit_flag), 32'd0);
  endtask

  task automatic t_passthru();
    match_char = 8'h00; wlen = 2'b11; det_en = 1'b1;
    cycle(8'hA5, 1'b1, 1'b0);
    chk("R2 valid", 32'(out_valid), 32'd1);
    chk("R2 data", 32'(out_data), 32'hA5);
    chk("R3 no match", 32'(hit_flag), 32'd0);
    cycle(8'h3C, 1'b0, 1'b0);
    chk("R2 idle valid", 32'(out_valid), 32'd0);
  endtask

  task automatic t_match_sticky();
    match_char = 8'h5A; wlen = 2'b11; det_en = 1'b1;
    cycle(8'h5A, 1'b1, 1'b0);
    chk("R3 flag with char", 32'(hit_flag), 32'd1);
    chk("R2 matching char kept", 32'(out_data), 32'h5A);
    chk("R2 matching valid", 32'(out_valid), 32'd1);
    repeat (3) cycle(8'h11, 1'b1, 1'b0);
    chk("R7 sticky", 32'(hit_flag), 32'd1);
    do_clear();
  endtask

  task automatic t_wlen();
    for (int c = 0; c < 4; c++) begin
      logic [7:0] base, d;
      base = 8'h00; wlen = 2'(c); match_char = base; det_en = 1'b1;
      if (c < 3) begin
        d = base ^ (8'h01 << (5 + c));
        cycle(d, 1'b1, 1'b0);
        chk($sformatf("R4 len code %0d bit above ignored", c), 32'(hit_flag),
            32'(exp_match(d, base, 2'(c))));
        do_clear();
      end
      d = base ^ (8'h01 << (4 + c));
      cycle(d, 1'b1, 1'b0);
      chk($sformatf("R4 len code %0d top bit compared", c), 32'(hit_flag),
          32'(exp_match(d, base, 2'(c))));
      do_clear();
    end
  endtask

  task automatic t_upper();
    wlen = 2'b00; match_char = 8'hE3; det_en = 1'b1;
    cycle(8'h03, 1'b1, 1'b0);
    chk("R5 upper bits ignored", 32'(hit_flag), 32'd1);
    chk("R5 data unchanged", 32'(out_data), 32'h03);
    do_clear();
  endtask

  task automatic t_disabled();
    wlen = 2'b11; match_char = 8'h7E; det_en = 1'b0;
    cycle(8'h7E, 1'b1, 1'b0);
    chk("R6 no set when disabled", 32'(hit_flag), 32'd0);
    chk("R6 data still passes", 32'(out_data), 32'h7E);
    det_en = 1'b1;
  endtask

  task automatic t_invalid();
    wlen = 2'b11; match_char = 8'h42; det_en = 1'b1;
    cycle(8'h42, 1'b0, 1'b0);
    chk("R9 no set without valid", 32'(hit_flag), 32'd0);
    chk("R9 valid low", 32'(out_valid), 32'd0);
  endtask

  task automatic t_race();
    wlen = 2'b11; match_char = 8'h99; det_en = 1'b1;
    cycle(8'h99, 1'b1, 1'b1);
    chk("R8 match beats clear", 32'(hit_flag), 32'd1);
    cycle(8'h12, 1'b1, 1'b1);
    chk("R7 clear with non-match", 32'(hit_flag), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_passthru();
    t_match_sticky();
    t_wlen();
    t_upper();
    t_disabled();
    t_invalid();
    t_race();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule